// File: doc/BRIEF.md
# Bus Mode and Global Configuration Controller

This block holds the global configuration word of a peripheral's host interface. It also runs the one-way change from asynchronous host bus cycles to synchronous ones. A host write to the configuration register updates three things at once: the interrupt vector control field, the power-down flag and the internal-address disable bit. Setting the synchronous-cycle bit in that write does not change the mode straight away. It arms the change, and the change takes effect on the first clock edge that samples chip enable released.

After the switch, a fixed quiet window follows in which the bus-ready output is low. A host cycle that begins inside that window is ignored and reported as a protocol violation. Once the interface is in synchronous mode, back-to-back writes may be issued without releasing chip enable. Only a hardware reset or a software reset command returns the interface to asynchronous mode.

The mode sequencer has four named states:
- ASYNC is the reset state.
- ASYNC goes to ARMED on a configuration write with bit 6 set.
- ARMED goes to QUIET on the first edge that samples chip enable high.
- QUIET goes to SYNC after `QUIET_CYC` edges.
- ARMED, ASYNC and SYNC all go to ASYNC on a software reset command.
- Every state goes to ASYNC on hardware reset.

Top module: `cfgbus_ctrl`

## Requirements
- R1: After hardware reset the outputs are: asynchronous mode (`sync_mode`=0), `bus_ready`=1, `ivc`=0, `pwr_down`=0, `addr_en`=1 and `proto_err`=0.
- R2: A configuration write (`cs_n`=0, `wr_en`=1, `cfg_sel`=1) loads `ivc` from data bits 2:1 and `pwr_down` from data bit 0, visible after the next edge. Data bits 5:3 have no effect.
- R3: Data bit 7 of a configuration write, when 1, drives `addr_en` low. A later write with bit 7 = 0 restores `addr_en` high.
- R4: A configuration write with bit 6 = 1 in asynchronous mode leaves `sync_mode` at 0 while `cs_n` stays low. `sync_mode` becomes 1 after the first edge that samples `cs_n` high.
- R5: `bus_ready` falls together with the rise of `sync_mode` and stays low for exactly `QUIET_CYC` (default 2) clock cycles.
- R6: A cycle with `cs_n` low while `bus_ready` is low raises `proto_err` for one cycle after that edge, and any write presented in it is ignored.
- R7: In synchronous mode, consecutive configuration writes with `cs_n` held low each take effect on their own edge.
- R8: In synchronous mode, a configuration write with bit 6 = 0 leaves `sync_mode` at 1.
- R9: A non-configuration write (`cfg_sel`=0) of `SWRST_CODE` (default 0xA5) at `CMD_ADDR` (default 0x8F) clears every field and returns the interface to asynchronous mode. Any other value at that address has no effect.
- R10: A hardware reset taken while in synchronous mode returns the interface to asynchronous mode with `bus_ready`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cs_n | input | 1 | Active-low chip enable |
| wr_en | input | 1 | Write strobe, active high |
| cfg_sel | input | 1 | Selects the configuration register |
| addr | input | ADDR_W | Bus address, decoded for the command address |
| wdata | input | DATA_W | Write data |
| sync_mode | output | 1 | 1 when synchronous bus cycles are in force |
| ivc | output | 2 | Interrupt vector control field |
| pwr_down | output | 1 | Power-down request; gates oscillator and internal engines |
| addr_en | output | 1 | Internal register addressing enable |
| bus_ready | output | 1 | Low during the post-switch quiet window |
| proto_err | output | 1 | One-cycle flag for a cycle started inside the quiet window |

## Verification
The bench holds chip enable low for several cycles after the arming write. A design that switched on the write itself, rather than on the release, would show synchronous mode early. It drives a write into the middle of the quiet window: a design that took that write would show the power-down bit set, and one that counted the window wrongly would show a ready pulse one cycle off. It then writes bit 6 back to zero and sends a wrong command value to the command address, either of which a faulty design would treat as a way back to asynchronous mode. Back-to-back writes without releasing chip enable catch a design that still waits for a release in synchronous mode.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;

    typedef enum logic [1:0] {
        S_ASYNC = 2'd0,
        S_ARMED = 2'd1,
        S_QUIET = 2'd2,
        S_SYNC  = 2'd3
    } bus_state_e;

    typedef struct packed {
        logic       addr_off;
        logic [1:0] ivc;
        logic       pd;
    } cfg_fields_t;

    localparam int BIT_ADDR_OFF = 7;
    localparam int BIT_SYNC     = 6;
    localparam int IVC_LSB      = 1;
    localparam int IVC_W        = 2;
    localparam int BIT_PD       = 0;

endpackage

// File: rtl/cfgbus_decode.sv
module cfgbus_decode #(
    parameter int              ADDR_W     = 8,
    parameter int              DATA_W     = 8,
    parameter logic [ADDR_W-1:0] CMD_ADDR = 8'h8F,
    parameter logic [DATA_W-1:0] SWRST_CODE = 8'hA5
) (
    input  logic              cs_n,
    input  logic              wr_en,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              accept,
    output logic              cfg_wr,
    output logic              swrst,
    output logic              arm_req
);
    import cfgbus_pkg::*;

    logic wr_cycle;

    always_comb begin
        wr_cycle = !cs_n && wr_en && accept;
        cfg_wr   = wr_cycle && cfg_sel;
        swrst    = wr_cycle && !cfg_sel && (addr == CMD_ADDR) && (wdata == SWRST_CODE);
        arm_req  = cfg_wr && wdata[BIT_SYNC];
    end

endmodule

// File: rtl/cfgbus_fields.sv
module cfgbus_fields (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic                     clear,
    input  cfgbus_pkg::cfg_fields_t  new_val,
    output cfgbus_pkg::cfg_fields_t  cur_val
);
    import cfgbus_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_val <= '0;
        end else if (clear) begin
            cur_val <= '0;
        end else if (load) begin
            cur_val <= new_val;
        end
    end

endmodule

// File: rtl/cfgbus_mode_fsm.sv
module cfgbus_mode_fsm #(
    parameter int QUIET_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic arm_req,
    input  logic swrst,
    output logic sync_mode,
    output logic bus_ready,
    output logic proto_err
);
    import cfgbus_pkg::*;

    localparam int CNT_W = (QUIET_CYC > 1) ? $clog2(QUIET_CYC) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUIET_CYC - 1);

    bus_state_e       state, state_nx;
    logic [CNT_W-1:0] qcnt, qcnt_nx;

    always_comb begin
        state_nx = state;
        qcnt_nx  = qcnt;
        unique case (state)
            S_ASYNC: begin
                if (arm_req) state_nx = S_ARMED;
            end
            S_ARMED: begin
                if (swrst) begin
                    state_nx = S_ASYNC;
                end else if (cs_n) begin
                    state_nx = S_QUIET;
                    qcnt_nx  = '0;
                end
            end
            S_QUIET: begin
                if (qcnt == CNT_LAST) state_nx = S_SYNC;
                else                  qcnt_nx  = qcnt + 1'b1;
            end
            S_SYNC: begin
                if (swrst) state_nx = S_ASYNC;
            end
            default: state_nx = S_ASYNC;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_ASYNC;
            qcnt  <= '0;
        end else begin
            state <= state_nx;
            qcnt  <= qcnt_nx;
        end
    end

    always_comb begin
        sync_mode = 1'b0;
        bus_ready = 1'b1;
        unique case (state)
            S_ASYNC: ;
            S_ARMED: ;
            S_QUIET: begin
                sync_mode = 1'b1;
                bus_ready = 1'b0;
            end
            S_SYNC:  sync_mode = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) proto_err <= 1'b0;
        else        proto_err <= (state == S_QUIET) && !cs_n;
    end

endmodule

// File: rtl/cfgbus_ctrl.sv
module cfgbus_ctrl #(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] CMD_ADDR   = 8'h8F,
    parameter logic [DATA_W-1:0] SWRST_CODE = 8'hA5,
    parameter int                QUIET_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_en,
    input  logic              cfg_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              sync_mode,
    output logic [1:0]        ivc,
    output logic              pwr_down,
    output logic              addr_en,
    output logic              bus_ready,
    output logic              proto_err
);
    import cfgbus_pkg::*;

    logic        cfg_wr, swrst, arm_req;
    logic        ready_int;
    cfg_fields_t fld_new, fld_cur;

    cfgbus_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CMD_ADDR  (CMD_ADDR),
        .SWRST_CODE(SWRST_CODE)
    ) u_dec (
        .cs_n   (cs_n),
        .wr_en  (wr_en),
        .cfg_sel(cfg_sel),
        .addr   (addr),
        .wdata  (wdata),
        .accept (ready_int),
        .cfg_wr (cfg_wr),
        .swrst  (swrst),
        .arm_req(arm_req)
    );

    always_comb begin
        fld_new.addr_off = wdata[BIT_ADDR_OFF];
        fld_new.ivc      = wdata[IVC_LSB +: IVC_W];
        fld_new.pd       = wdata[BIT_PD];
    end

    cfgbus_fields u_fld (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cfg_wr),
        .clear  (swrst),
        .new_val(fld_new),
        .cur_val(fld_cur)
    );

    cfgbus_mode_fsm #(
        .QUIET_CYC(QUIET_CYC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .arm_req  (arm_req),
        .swrst    (swrst),
        .sync_mode(sync_mode),
        .bus_ready(ready_int),
        .proto_err(proto_err)
    );

    assign bus_ready = ready_int;
    assign ivc       = fld_cur.ivc;
    assign pwr_down  = fld_cur.pd;
    assign addr_en   = !fld_cur.addr_off;

endmodule

// File: rtl/cfgbus_chk.sv
module cfgbus_chk #(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] CMD_ADDR   = 8'h8F,
    parameter logic [DATA_W-1:0] SWRST_CODE = 8'hA5,
    parameter int                QUIET_CYC  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              wr_en,
    input logic              cfg_sel,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              sync_mode,
    input logic              bus_ready,
    input logic              proto_err
);
    logic [7:0] low_cnt;
    logic       cmd_hit;

    assign cmd_hit = !cs_n && wr_en && !cfg_sel && (addr == CMD_ADDR) && (wdata == SWRST_CODE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          low_cnt <= '0;
        else if (!bus_ready) low_cnt <= low_cnt + 8'd1;
        else                 low_cnt <= '0;
    end

    // R4
    switch_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_mode) |-> $past(cs_n));

    // R5
    ready_drops_with_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_mode) |-> !bus_ready);

    // R5
    quiet_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ready) |-> (low_cnt == 8'(QUIET_CYC)));

    // R6
    viol_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> $past(!bus_ready && !cs_n));

    // R8
    leave_sync_only_by_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_mode) |-> $past(cmd_hit));

endmodule

bind cfgbus_ctrl cfgbus_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CMD_ADDR  (CMD_ADDR),
    .SWRST_CODE(SWRST_CODE),
    .QUIET_CYC (QUIET_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .wr_en    (wr_en),
    .cfg_sel  (cfg_sel),
    .addr     (addr),
    .wdata    (wdata),
    .sync_mode(sync_mode),
    .bus_ready(bus_ready),
    .proto_err(proto_err)
);

// File: tb/sim_cfgbus_ctrl.sv
`timescale 1ns/1ps
module sim_cfgbus_ctrl;

    logic       clk = 1'b0;
    logic       rst_n, cs_n, wr_en, cfg_sel;
    logic [7:0] addr, wdata;
    logic       sync_mode, pwr_down, addr_en, bus_ready, proto_err;
    logic [1:0] ivc;

    int n_chk = 0;
    int n_bad = 0;
    int cyc_cnt = 0;

    always #4 clk = ~clk;

    cfgbus_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_en(wr_en), .cfg_sel(cfg_sel),
        .addr(addr), .wdata(wdata), .sync_mode(sync_mode), .ivc(ivc),
        .pwr_down(pwr_down), .addr_en(addr_en), .bus_ready(bus_ready),
        .proto_err(proto_err)
    );

    // behavioural reference
    bit m_sync, m_armed, m_rsv, m_pd, m_err;
    int m_ivc, m_quiet;

    always @(posedge clk) begin
        bit wr, cfgw, cmdw;
        cyc_cnt++;
        if (!rst_n) begin
            m_sync = 0; m_armed = 0; m_rsv = 0; m_pd = 0; m_err = 0;
            m_ivc = 0; m_quiet = 0;
        end else begin
            wr   = !cs_n && wr_en;
            cfgw = wr && cfg_sel;
            cmdw = wr && !cfg_sel && addr == 8'h8F && wdata == 8'hA5;
            m_err = (m_quiet > 0) && !cs_n;
            if (m_quiet > 0) begin
                m_quiet--;
            end else if (cmdw) begin
                m_sync = 0; m_armed = 0; m_rsv = 0; m_pd = 0; m_ivc = 0;
            end else begin
                if (m_armed && cs_n) begin
                    m_armed = 0; m_sync = 1; m_quiet = 2;
                end
                if (cfgw) begin
                    m_rsv = wdata[7];
                    m_ivc = wdata[2:1];
                    m_pd  = wdata[0];
                    if (wdata[6] && !m_sync) m_armed = 1;
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cyc_cnt > 0) begin
            chk("R2", "ivc",       ivc,       m_ivc);
            chk("R2", "pwr_down",  pwr_down,  m_pd);
            chk("R3", "addr_en",   addr_en,   !m_rsv);
            chk("R4", "sync_mode", sync_mode, m_sync);
            chk("R5", "bus_ready", bus_ready, m_quiet == 0);
            chk("R6", "proto_err", proto_err, m_err);
        end
    end

    task automatic cyc(input bit cs, input bit we, input bit sel, input logic [7:0] a, input logic [7:0] d);
        #1;
        cs_n = cs; wr_en = we; cfg_sel = sel; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1, 0, 0, 8'h00, 8'h00);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #80000;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 0; cs_n = 1; wr_en = 0; cfg_sel = 0; addr = 0; wdata = 0;
        idle(3);
        #1 rst_n = 1;
        idle(1);
        // R1
        chk("R1", "sync_mode", sync_mode, 0);
        chk("R1", "bus_ready", bus_ready, 1);
        chk("R1", "ivc",       ivc,       0);
        chk("R1", "pwr_down",  pwr_down,  0);
        chk("R1", "addr_en",   addr_en,   1);
        chk("R1", "proto_err", proto_err, 0);

        // R2: reserved bits 5:3 set alongside ivc=2, pd=1
        cyc(0, 1, 1, 8'h00, 8'h3D);
        chk("R2", "ivc", ivc, 2);
        chk("R2", "pwr_down", pwr_down, 1);
        chk("R2", "sync_mode", sync_mode, 0);
        idle(1);

        // R3
        cyc(0, 1, 1, 8'h00, 8'h80);
        chk("R3", "addr_en", addr_en, 0);
        idle(1);
        cyc(0, 1, 1, 8'h00, 8'h00);
        chk("R3", "addr_en", addr_en, 1);
        idle(1);

        // R4: arm, hold chip enable low
        cyc(0, 1, 1, 8'h00, 8'h42);
        chk("R4", "sync_mode armed", sync_mode, 0);
        cyc(0, 0, 1, 8'h00, 8'h00);
        cyc(0, 0, 1, 8'h00, 8'h00);
        chk("R4", "sync_mode held", sync_mode, 0);
        idle(1);
        chk("R4", "sync_mode released", sync_mode, 1);
        chk("R5", "bus_ready q1", bus_ready, 0);
        // R6: write into the quiet window
        cyc(0, 1, 1, 8'h00, 8'h07);
        chk("R6", "proto_err", proto_err, 1);
        chk("R6", "pwr_down ignored", pwr_down, 0);
        chk("R5", "bus_ready q2", bus_ready, 0);
        idle(1);
        chk("R5", "bus_ready after", bus_ready, 1);
        chk("R6", "proto_err clear", proto_err, 0);
        chk("R6", "ivc ignored", ivc, 1);

        // R7 / R8: back-to-back sync writes, bit 6 cleared
        cyc(0, 1, 1, 8'h00, 8'h02);
        chk("R7", "ivc w1", ivc, 1);
        cyc(0, 1, 1, 8'h00, 8'h04);
        chk("R7", "ivc w2", ivc, 2);
        cyc(0, 1, 1, 8'h00, 8'h05);
        chk("R7", "pwr_down w3", pwr_down, 1);
        chk("R8", "sync_mode kept", sync_mode, 1);
        idle(2);
        chk("R8", "sync_mode kept idle", sync_mode, 1);

        // R9: wrong code, then right code
        cyc(0, 1, 0, 8'h8F, 8'h5A);
        chk("R9", "sync_mode wrong code", sync_mode, 1);
        chk("R9", "pwr_down wrong code", pwr_down, 1);
        idle(1);
        cyc(0, 1, 0, 8'h8F, 8'hA5);
        chk("R9", "sync_mode", sync_mode, 0);
        chk("R9", "pwr_down", pwr_down, 0);
        chk("R9", "ivc", ivc, 0);
        chk("R9", "bus_ready", bus_ready, 1);
        idle(1);

        // R10: back to sync, then hardware reset
        cyc(0, 1, 1, 8'h00, 8'h43);
        idle(4);
        chk("R10", "sync_mode before", sync_mode, 1);
        #1 rst_n = 0;
        idle(1);
        chk("R10", "sync_mode", sync_mode, 0);
        chk("R10", "bus_ready", bus_ready, 1);
        chk("R10", "pwr_down", pwr_down, 0);
        #1 rst_n = 1;
        idle(2);
        finish_run();
    end

endmodule